// File: doc/BRIEF.md
# Configurable Serial PCM Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame clock and data) and turns it into parallel left and right sample words, each announced by a one-cycle strobe. Everything runs in a single system clock domain. All three serial lines are oversampled through a two-stage synchronizer, and edges of the bit clock are found by comparing consecutive synchronized values.

A small control register selects one of four frame formats: right-justified, left-justified, I2S-style and a pulse-framed DSP format. It also sets the word length to 16, 20, 24 or 32 bits. One control bit has two meanings. In the level-framed formats it inverts the frame clock. In the DSP format it chooses between variant A and variant B. A second bit moves bit capture to the falling edge of the bit clock.

A second register holds a two-bit oversampling-rate code. The block does not use this code itself. It passes the code to downstream processing and raises a flag when the unused code is written.

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset, both strobes, both data words, the rate code, the invalid-rate flag and the register read data are all zero. The first capture decision also treats the previous frame-clock level as 0.
- R2: Register 05h is laid out as follows.
  - Bits [1:0] hold the format: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP.
  - Bits [3:2] hold the word length: 00 = 16, 01 = 20, 10 = 24, 11 = 32 bits.
  - Bit 4 holds the polarity/variant control.
  - Bit 5 holds the edge select.
  - Register 07h keeps the rate code in bits [6:5].
  - A read returns the addressed register one clock later, with the other bits zero. Unmapped addresses read zero.
- R3: The rate code output follows bits [6:5] of register 07h: 00 = 32/44.1/48 kHz, 01 = 96 kHz, 10 = 192 kHz. The invalid flag is high exactly while the stored code is 11, and the code 11 still reads back as written.
- R4: With the edge select at 0, the frame clock and data are captured on rising bit-clock edges. With the edge select at 1, they are captured on falling edges.
- R5: Words arrive MSB first. They are delivered right-aligned with the bits above the word length set to zero.
- R6: In the level-framed formats, the effective level is the frame clock XOR the polarity bit. An effective level of 0 marks the left channel and 1 marks the right channel, so setting the polarity bit makes a high frame clock mean left.
- R7: In left-justified format, the MSB is the first bit captured after a change of effective level. The word is delivered once its last bit has been captured.
- R8: In I2S format, the MSB is the second bit captured after a change of effective level.
- R9: In right-justified format, the LSB is the last bit captured before the next change of effective level. The word for the ending channel is delivered when that change is captured. No word is delivered before the first change after reset.
- R10: In DSP format, a frame starts at a captured rising frame clock, and the right word follows the left word with no gap. The variant is chosen by the polarity bit:
  - Variant A (bit 4 = 0): the left MSB is the bit after the pulse bit.
  - Variant B (bit 4 = 1): the left MSB is carried in the pulse bit itself.
- R11: Each strobe lasts one cycle, the two strobes are never high together, and a strobe only follows a capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial bit clock (asynchronous) |
| fclk_in | input | 1 | Serial frame clock or frame pulse (asynchronous) |
| sdata_in | input | 1 | Serial data (asynchronous) |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register address for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| left_data | output | 32 | Left sample, right-aligned |
| left_vld | output | 1 | Left sample strobe |
| right_data | output | 32 | Right sample, right-aligned |
| right_vld | output | 1 | Right sample strobe |
| rate_sel | output | 2 | Oversampling-rate code for downstream logic |
| rate_bad | output | 1 | Stored rate code is the unused value |

## Verification
Each format is driven with random sample pairs at several word lengths. A word length shorter than the half-frame separates the left-justified, I2S and right-justified bit positions, because those formats differ only in where the word sits within the half-frame. Both settings of the polarity bit are used on level-framed streams, so a channel swap shows up as words arriving on the wrong strobe. Both edge settings are used, and the sender changes data on the edge that is not captured, so sampling on the wrong edge corrupts every word. The DSP runs use both variants, which differ by one bit position, so a variant mix-up shows up as a one-bit shift in every sample.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // Field order matches register bits [5:0]
  typedef struct packed {
    logic       edge_inv;
    logic       pol_var;
    logic [1:0] wlen;
    fmt_e       fmt;
  } fmt_cfg_t;

  function automatic logic [5:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd16;
      2'b01:   return 6'd20;
      2'b10:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/pcm_rx_cfg.sv
module pcm_rx_cfg
  import pcm_rx_pkg::*;
#(
  parameter int             AW        = 8,
  parameter int             DW        = 8,
  parameter logic [AW-1:0]  FMT_ADDR  = 'h05,
  parameter logic [AW-1:0]  RATE_ADDR = 'h07,
  parameter int             RATE_LSB  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output fmt_cfg_t      cfg,
  output logic [1:0]    rate,
  output logic          rate_bad
);

  localparam int CW = $bits(fmt_cfg_t);

  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr == FMT_ADDR)
      rd_mux[CW-1:0] = cfg;
    else if (addr == RATE_ADDR)
      rd_mux[RATE_LSB +: 2] = rate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= fmt_cfg_t'('0);
      rate     <= '0;
      rate_bad <= 1'b0;
      rdata    <= '0;
    end else begin
      rdata <= rd_mux;
      if (wr_en && addr == FMT_ADDR)
        cfg <= fmt_cfg_t'(wdata[CW-1:0]);
      if (wr_en && addr == RATE_ADDR) begin
        rate     <= wdata[RATE_LSB +: 2];
        rate_bad <= &wdata[RATE_LSB +: 2];
      end
    end
  end

endmodule

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/pcm_rx_deframe.sv
module pcm_rx_deframe
  import pcm_rx_pkg::*;
#(
  parameter int MAXW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_s,
  input  logic            fclk_s,
  input  logic            sdat_s,
  input  fmt_cfg_t        cfg,
  output logic            cap_evt,
  output logic [MAXW-1:0] left_data,
  output logic            left_vld,
  output logic [MAXW-1:0] right_data,
  output logic            right_vld
);

  localparam int            PW   = $clog2(2*MAXW + 2) + 1;
  localparam logic [PW-1:0] PMAX = '1;

  logic            sclk_d, lvl_prev, synced;
  logic [PW-1:0]   pos, pos_cur, wl, start, l_end, r_end;
  logic [MAXW-1:0] sr, sr_new, mask, word;
  logic            is_dsp, lvl, evt, emit_l, emit_r;

  always_comb begin
    cap_evt = cfg.edge_inv ? (!sclk_s && sclk_d) : (sclk_s && !sclk_d);
    is_dsp  = (cfg.fmt == FMT_DSP);
    lvl     = is_dsp ? fclk_s : (fclk_s ^ cfg.pol_var);
    evt     = is_dsp ? (lvl && !lvl_prev) : (lvl != lvl_prev);
    pos_cur = evt ? '0 : ((pos == PMAX) ? PMAX : pos + 1'b1);
    sr_new  = {sr[MAXW-2:0], sdat_s};
    wl      = PW'(wlen_bits(cfg.wlen));
    mask    = {MAXW{1'b1}} >> (PW'(MAXW) - wl);
    if (is_dsp) start = cfg.pol_var ? '0 : PW'(1);
    else        start = (cfg.fmt == FMT_I2S) ? PW'(1) : '0;
    l_end   = start + wl - 1'b1;
    r_end   = l_end + wl;
    emit_l  = 1'b0;
    emit_r  = 1'b0;
    word    = sr_new & mask;
    case (cfg.fmt)
      FMT_RJ: begin
        word   = sr & mask;
        emit_l = evt && synced && !lvl_prev;
        emit_r = evt && synced &&  lvl_prev;
      end
      FMT_DSP: begin
        emit_l = (pos_cur == l_end);
        emit_r = (pos_cur == r_end);
      end
      default: begin
        emit_l = (pos_cur == l_end) && !lvl;
        emit_r = (pos_cur == l_end) &&  lvl;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      lvl_prev   <= 1'b0;
      synced     <= 1'b0;
      pos        <= PMAX;
      sr         <= '0;
      left_data  <= '0;
      right_data <= '0;
      left_vld   <= 1'b0;
      right_vld  <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      left_vld  <= 1'b0;
      right_vld <= 1'b0;
      if (cap_evt) begin
        sr       <= sr_new;
        lvl_prev <= lvl;
        pos      <= pos_cur;
        if (evt) synced <= 1'b1;
        if (emit_l) begin
          left_data <= word;
          left_vld  <= 1'b1;
        end
        if (emit_r) begin
          right_data <= word;
          right_vld  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int MAXW = 32,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_in,
  input  logic            fclk_in,
  input  logic            sdata_in,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  output logic [MAXW-1:0] left_data,
  output logic            left_vld,
  output logic [MAXW-1:0] right_data,
  output logic            right_vld,
  output logic [1:0]      rate_sel,
  output logic            rate_bad
);

  fmt_cfg_t   cfg;
  logic [2:0] ser_s;
  logic       cap_evt;

  pcm_rx_cfg #(.AW(8), .DW(8)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg), .rate(rate_sel), .rate_bad(rate_bad)
  );

  pcm_rx_sync #(.N(3), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .din({sdata_in, fclk_in, sclk_in}), .dout(ser_s)
  );

  pcm_rx_deframe #(.MAXW(MAXW)) u_defr (
    .clk(clk), .rst(rst), .sclk_s(ser_s[0]), .fclk_s(ser_s[1]), .sdat_s(ser_s[2]),
    .cfg(cfg), .cap_evt(cap_evt),
    .left_data(left_data), .left_vld(left_vld),
    .right_data(right_data), .right_vld(right_vld)
  );

endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk #(
  parameter logic [7:0] RATE_ADDR = 8'h07
) (
  input logic       clk,
  input logic       rst,
  input logic       left_vld,
  input logic       right_vld,
  input logic       cap_evt,
  input logic       cfg_wr,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       rate_bad
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: no strobe in the cycle after reset
  always_ff @(posedge clk)
    if (rst_q && !rst) a_r1_quiet_after_reset: assert (!left_vld && !right_vld);

  // R11
  a_r11_left_one_cycle: assert property (@(posedge clk) disable iff (rst)
    left_vld |=> !left_vld);
  a_r11_right_one_cycle: assert property (@(posedge clk) disable iff (rst)
    right_vld |=> !right_vld);
  a_r11_never_both: assert property (@(posedge clk) disable iff (rst)
    !(left_vld && right_vld));
  a_r11_after_capture: assert property (@(posedge clk) disable iff (rst)
    (left_vld || right_vld) |-> $past(cap_evt));

  // R3
  a_r3_bad_code_flag: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == RATE_ADDR) |=> (rate_bad == (&$past(cfg_wdata[6:5]))));

endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
  .clk(clk), .rst(rst), .left_vld(left_vld), .right_vld(right_vld),
  .cap_evt(cap_evt), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .rate_bad(rate_bad)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;

  logic        clk = 0;
  logic        rst = 1;
  logic        sclk_in = 0, fclk_in = 0, sdata_in = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 0, cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic [31:0] left_data, right_data;
  logic        left_vld, right_vld;
  logic [1:0]  rate_sel;
  logic        rate_bad;

  int n_chk = 0, n_fail = 0;
  logic cap_hi = 1;
  logic [31:0] exp_l[$], exp_r[$];

  always #4 clk = ~clk;

  pcm_serial_rx u_dut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .fclk_in(fclk_in), .sdata_in(sdata_in),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .left_data(left_data), .left_vld(left_vld), .right_data(right_data),
    .right_vld(right_vld), .rate_sel(rate_sel), .rate_bad(rate_bad)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (left_vld) begin
        if (exp_l.size() == 0) check(0, "R5-R10 unexpected left word", left_data, 0);
        else begin
          automatic logic [31:0] e = exp_l.pop_front();
          check(left_data == e, "R5 left word", left_data, e);
        end
      end
      if (right_vld) begin
        if (exp_r.size() == 0) check(0, "R5-R10 unexpected right word", right_data, 0);
        else begin
          automatic logic [31:0] e = exp_r.pop_front();
          check(right_data == e, "R5 right word", right_data, e);
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1; sclk_in = ~cap_hi; fclk_in = 0; sdata_in = 0;
    tick(3); rst = 0; tick(2);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d; tick(1); cfg_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] expv, input string req);
    cfg_addr = a; tick(1);
    check(cfg_rdata == expv, req, {24'd0, cfg_rdata}, {24'd0, expv});
  endtask

  task automatic sbit(input logic f, input logic d);
    sclk_in = ~cap_hi; fclk_in = f; sdata_in = d; tick(4);
    sclk_in = cap_hi; tick(4);
  endtask

  function automatic int wbits(input logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 20 : (c == 2) ? 24 : 32;
  endfunction

  function automatic logic [31:0] rnd(input int w);
    logic [31:0] v = $urandom;
    return (w == 32) ? v : (v & ((32'd1 << w) - 1));
  endfunction

  // fmt: 0 RJ, 1 LJ, 2 I2S (R7, R8, R9, R6)
  task automatic half(input logic [1:0] fmt, input int w, input logic ch, input logic pol, input logic [31:0] v);
    localparam int H = 34;
    for (int p = 0; p < H; p++) begin
      logic d = 0;
      if (fmt == 1 && p < w) d = v[w-1-p];
      if (fmt == 2 && p >= 1 && p <= w) d = v[w-p];
      if (fmt == 0 && p >= H - w) d = v[H-1-p];
      sbit(ch ^ pol, d);
    end
  endtask

  task automatic run_pcm(input logic [1:0] fmt, input logic [1:0] wc, input logic pol, input logic edg, input int nf);
    int w = wbits(wc);
    cap_hi = ~edg;
    do_reset();
    wr(8'h05, {2'b00, edg, pol, wc, fmt});
    exp_r.push_back(0);
    half(fmt, w, 1'b1, pol, 0);
    for (int f = 0; f < nf; f++) begin
      logic [31:0] l = rnd(w), r = rnd(w);
      exp_l.push_back(l); exp_r.push_back(r);
      half(fmt, w, 1'b0, pol, l);
      half(fmt, w, 1'b1, pol, r);
    end
    sbit(pol, 0);
    tick(12);
    check(exp_l.size() == 0 && exp_r.size() == 0, "R4/R6 all words delivered",
          exp_l.size() + exp_r.size(), 0);
    exp_l.delete(); exp_r.delete();
  endtask

  // R10
  task automatic run_dsp(input logic [1:0] wc, input logic var_b, input logic edg, input int nf);
    int w = wbits(wc);
    cap_hi = ~edg;
    do_reset();
    wr(8'h05, {2'b00, edg, var_b, wc, 2'b11});
    for (int f = 0; f < nf; f++) begin
      logic [31:0] l = rnd(w), r = rnd(w);
      exp_l.push_back(l); exp_r.push_back(r);
      for (int p = 0; p < 72; p++) begin
        int idx = p - (var_b ? 0 : 1);
        logic d = 0;
        if (idx >= 0 && idx < w) d = l[w-1-idx];
        else if (idx >= w && idx < 2*w) d = r[2*w-1-idx];
        sbit(p == 0, d);
      end
    end
    tick(12);
    check(exp_l.size() == 0 && exp_r.size() == 0, "R10 all DSP words delivered",
          exp_l.size() + exp_r.size(), 0);
    exp_l.delete(); exp_r.delete();
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    check(!left_vld && !right_vld && left_data == 0 && right_data == 0, "R1 outputs idle",
          {left_data[29:0], left_vld, right_vld}, 0);
    check(rate_sel == 0 && !rate_bad, "R1 rate reset", {rate_bad, rate_sel}, 0);
    rd_chk(8'h05, 8'h00, "R1 format reg reset");
    rd_chk(8'h07, 8'h00, "R1 rate reg reset");
    // R2, R3
    wr(8'h05, 8'h3F);
    rd_chk(8'h05, 8'h3F, "R2 format reg readback");
    rd_chk(8'h06, 8'h00, "R2 unmapped address");
    wr(8'h07, 8'h60);
    check(rate_sel == 2'b11 && rate_bad, "R3 unused code flagged", {rate_bad, rate_sel}, 3'b111);
    rd_chk(8'h07, 8'h60, "R3 unused code reads back");
    wr(8'h07, 8'hBF);
    check(rate_sel == 2'b01 && !rate_bad, "R3 96k code", {rate_bad, rate_sel}, 3'b001);
    rd_chk(8'h07, 8'h20, "R2 rate field only");
    wr(8'h07, 8'h40);
    check(rate_sel == 2'b10 && !rate_bad, "R3 192k code", {rate_bad, rate_sel}, 3'b010);
    // serial formats
    run_pcm(2'b01, 2'b00, 1'b0, 1'b0, 3); // R7 LJ 16, rising edge
    run_pcm(2'b01, 2'b11, 1'b1, 1'b1, 3); // R7 R6 LJ 32 inverted, falling edge R4
    run_pcm(2'b10, 2'b10, 1'b0, 1'b1, 3); // R8 I2S 24
    run_pcm(2'b10, 2'b11, 1'b1, 1'b0, 3); // R8 I2S 32 inverted
    run_pcm(2'b00, 2'b01, 1'b1, 1'b0, 3); // R9 RJ 20 inverted
    run_pcm(2'b00, 2'b11, 1'b0, 1'b1, 3); // R9 RJ 32
    run_dsp(2'b00, 1'b0, 1'b0, 3);        // R10 variant A
    run_dsp(2'b10, 1'b1, 1'b1, 3);        // R10 variant B, falling edge
    run_dsp(2'b11, 1'b0, 1'b1, 2);        // R10 variant A, 32 bits
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule